// File: doc/BRIEF.md
# Configurable Pipelined Signed Multiplier

This block multiplies two 18-bit two's complement operands and returns their full 36-bit two's complement product. No bits are lost. Three optional registers can be placed in the datapath: one on operand A, one on operand B and one on the product. Each register is included or left out when the design is built, so the path from an operand to the product takes 0, 1 or 2 clock cycles.

All present registers run on one clock. Each register has its own clock enable and its own synchronous clear. This lets an operand register hold a coefficient or a data sample for as long as needed. A chip-level active-low asynchronous reset also clears every present register.

A small front end, `umul17_wrap`, performs unsigned multiplication. It takes two 17-bit unsigned values, drives a 0 into the sign bit of each operand and returns the 34-bit unsigned product. Operands narrower than 18 bits are used by copying their sign bit into the unused upper bits.

Top module: `smul_pipe`

## Requirements
- R1: `p_o` equals the exact signed product of the effective A and B operands, as a 36-bit two's complement value. This holds at the corners: (-131072)×(-131072)=17179869184, (-131072)×131071=-17179738112, (-1)×(-1)=1, and 0×anything=0.
- R2: The delay from operand A to `p_o` is USE_AREG+USE_PREG cycles. The delay from operand B to `p_o` is USE_BREG+USE_PREG cycles. Each parameter is 1 to include its register and 0 to leave it out.
- R3: A present register loads its input at a rising clock edge when its enable is 1 and its clear is 0.
- R4: A present register keeps its value at a rising edge when its enable is 0 and its clear is 0.
- R5: A present register becomes zero at a rising edge when its clear is 1, whatever its enable is.
- R6: When a register is left out, its enable and clear have no effect, and its output follows its input in the same cycle.
- R7: While `rst_n` is 0, every present register is zero, without waiting for a clock edge.
- R8: `umul17_wrap` returns the 34-bit unsigned product of its two 17-bit unsigned inputs two cycles after they are applied, with its enable at 1.
- R9: Each enable and each clear acts only on its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all present registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | Operand A, two's complement |
| b_i | input | 18 | Operand B, two's complement |
| a_ce | input | 1 | Enable for the A register |
| b_ce | input | 1 | Enable for the B register |
| p_ce | input | 1 | Enable for the product register |
| a_srst | input | 1 | Synchronous clear for the A register |
| b_srst | input | 1 | Synchronous clear for the B register |
| p_srst | input | 1 | Synchronous clear for the product register |
| p_o | output | 36 | Product, two's complement |

## Verification
On every cycle, the assertions check each present register's response to its own enable and clear: load, hold, and clear taking priority. They also check that a left-out stage passes its input straight through, and that an unregistered product matches the current operands. Some behaviours can only be shown by the bench's scenarios, because they span configurations or depend on values. These are the end-to-end delay in all eight register combinations, the extreme operand corners, the effect of an asynchronous reset in the middle of a run, and the unsigned front end.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // default operand width of the multiplier
  localparam int SMUL_OP_W = 18;
  // product carries full precision
  localparam int SMUL_PROD_W = 2 * SMUL_OP_W;
endpackage

// File: rtl/smul_stage.sv
// Optional register stage: present (EN != 0) or a plain wire (EN == 0).
module smul_stage #(
  parameter int W  = 18,
  parameter int EN = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_i,
  input  logic         srst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (EN != 0) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      // clear wins over enable
      always_comb begin
        if (srst_i)    q_nxt = '0;
        else if (ce_i) q_nxt = d_i;
        else           q_nxt = q_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q_o = q_r;
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, ce_i, srst_i};
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/smul_core.sv
// Combinational full-precision two's complement product.
module smul_core #(
  parameter int OP_W = 18
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] p_o
);
  localparam int PW  = 2 * OP_W;
  localparam int EXT = PW - OP_W;

  logic [PW-1:0] a_x;
  logic [PW-1:0] b_x;

  // sign extension to the product width; the low PW bits of the
  // unsigned product of the extended words are the signed product
  assign a_x = {{EXT{a_i[OP_W-1]}}, a_i};
  assign b_x = {{EXT{b_i[OP_W-1]}}, b_i};
  assign p_o = a_x * b_x;
endmodule

// File: rtl/umul17_wrap.sv
// Unsigned front end: sign bit of each operand held at zero.
module umul17_wrap import smul_pkg::*; #(
  parameter int OP_W     = SMUL_OP_W,
  parameter int USE_AREG = 1,
  parameter int USE_BREG = 1,
  parameter int USE_PREG = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic                srst_i,
  input  logic [OP_W-2:0]     ua_i,
  input  logic [OP_W-2:0]     ub_i,
  output logic [2*OP_W-3:0]   up_o
);
  localparam int PW = 2 * OP_W;

  logic [PW-1:0] p_full;
  logic          unused_top;

  smul_pipe #(
    .OP_W(OP_W), .USE_AREG(USE_AREG), .USE_BREG(USE_BREG), .USE_PREG(USE_PREG)
  ) u_mul (
    .clk(clk), .rst_n(rst_n),
    .a_i({1'b0, ua_i}), .b_i({1'b0, ub_i}),
    .a_ce(ce_i), .b_ce(ce_i), .p_ce(ce_i),
    .a_srst(srst_i), .b_srst(srst_i), .p_srst(srst_i),
    .p_o(p_full)
  );

  // two non-negative operands: top two product bits are always zero
  assign up_o       = p_full[PW-3:0];
  assign unused_top = ^p_full[PW-1:PW-2];
endmodule

// File: rtl/smul_pipe.sv
module smul_pipe import smul_pkg::*; #(
  parameter int OP_W     = SMUL_OP_W,
  parameter int USE_AREG = 1,
  parameter int USE_BREG = 1,
  parameter int USE_PREG = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     a_i,
  input  logic [OP_W-1:0]     b_i,
  input  logic                a_ce,
  input  logic                b_ce,
  input  logic                p_ce,
  input  logic                a_srst,
  input  logic                b_srst,
  input  logic                p_srst,
  output logic [2*OP_W-1:0]   p_o
);
  localparam int PW = 2 * OP_W;

  logic [OP_W-1:0] a_q;
  logic [OP_W-1:0] b_q;
  logic [PW-1:0]   prod_c;

  smul_stage #(.W(OP_W), .EN(USE_AREG)) u_areg (
    .clk(clk), .rst_n(rst_n), .ce_i(a_ce), .srst_i(a_srst),
    .d_i(a_i), .q_o(a_q)
  );

  smul_stage #(.W(OP_W), .EN(USE_BREG)) u_breg (
    .clk(clk), .rst_n(rst_n), .ce_i(b_ce), .srst_i(b_srst),
    .d_i(b_i), .q_o(b_q)
  );

  smul_core #(.OP_W(OP_W)) u_core (
    .a_i(a_q), .b_i(b_q), .p_o(prod_c)
  );

  smul_stage #(.W(PW), .EN(USE_PREG)) u_preg (
    .clk(clk), .rst_n(rst_n), .ce_i(p_ce), .srst_i(p_srst),
    .d_i(prod_c), .q_o(p_o)
  );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int OP_W     = 18,
  parameter int USE_AREG = 1,
  parameter int USE_BREG = 1,
  parameter int USE_PREG = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [OP_W-1:0]     a_i,
  input logic [OP_W-1:0]     b_i,
  input logic [OP_W-1:0]     a_q,
  input logic [OP_W-1:0]     b_q,
  input logic                a_ce,
  input logic                b_ce,
  input logic                p_ce,
  input logic                a_srst,
  input logic                b_srst,
  input logic                p_srst,
  input logic [2*OP_W-1:0]   p_o
);
  localparam int PW = 2 * OP_W;

  logic [PW-1:0] ref_prod;
  logic          unused_chk;

  assign ref_prod   = {{OP_W{a_q[OP_W-1]}}, a_q} * {{OP_W{b_q[OP_W-1]}}, b_q};
  assign unused_chk = ^{a_i, b_i, a_ce, b_ce, p_ce, a_srst, b_srst, p_srst};

  generate
    if (USE_AREG != 0) begin : g_a
      // R5
      a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_srst |=> (a_q == '0));
      // R4
      a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_srst && !a_ce) |=> $stable(a_q));
      // R3
      a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_srst && a_ce) |=> (a_q == $past(a_i)));
    end else begin : g_an
      // R6
      a_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_q == a_i);
    end

    if (USE_BREG != 0) begin : g_b
      // R5
      b_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_srst |=> (b_q == '0));
      // R4
      b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_srst && !b_ce) |=> $stable(b_q));
      // R3
      b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_srst && b_ce) |=> (b_q == $past(b_i)));
    end else begin : g_bn
      // R6
      b_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_q == b_i);
    end

    if (USE_PREG != 0) begin : g_p
      // R5
      p_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_srst |=> (p_o == '0));
      // R4
      p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_srst && !p_ce) |=> $stable(p_o));
      // R1
      p_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_srst && p_ce) |=> (p_o == $past(ref_prod)));
    end else begin : g_pn
      // R1
      p_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_o == ref_prod);
    end
  endgenerate
endmodule

bind smul_pipe smul_chk #(
  .OP_W(OP_W), .USE_AREG(USE_AREG), .USE_BREG(USE_BREG), .USE_PREG(USE_PREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .a_q(a_q), .b_q(b_q),
  .a_ce(a_ce), .b_ce(b_ce), .p_ce(p_ce),
  .a_srst(a_srst), .b_srst(b_srst), .p_srst(p_srst), .p_o(p_o)
);

// File: tb/sim_smul_pipe.sv
module sim_smul_pipe;
  localparam int PERIOD = 10;
  localparam int NCFG   = 8;

  logic clk;
  logic rst_n;
  logic [17:0] a_in, b_in;
  logic a_ce, b_ce, p_ce, a_srst, b_srst, p_srst;
  logic [35:0] pv [NCFG];

  logic        w_ce, w_srst;
  logic [16:0] ua, ub;
  logic [33:0] up;

  int    checks   = 0;
  int    failures = 0;
  bit    running  = 0;
  bit    done     = 0;
  string tag      = "R7";

  // configuration index: bit0 = A register, bit1 = B register, bit2 = product register
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    smul_pipe #(
      .USE_AREG(g % 2), .USE_BREG((g / 2) % 2), .USE_PREG((g / 4) % 2)
    ) u0 (
      .clk(clk), .rst_n(rst_n), .a_i(a_in), .b_i(b_in),
      .a_ce(a_ce), .b_ce(b_ce), .p_ce(p_ce),
      .a_srst(a_srst), .b_srst(b_srst), .p_srst(p_srst),
      .p_o(pv[g])
    );
  end

  umul17_wrap uw (
    .clk(clk), .rst_n(rst_n), .ce_i(w_ce), .srst_i(w_srst),
    .ua_i(ua), .ub_i(ub), .up_o(up)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  // behavioural reference state per configuration
  longint ma [NCFG];
  longint mb [NCFG];
  longint mp [NCFG];

  function automatic longint sv18(logic [17:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint eff_a(int c);
    return (c % 2 != 0) ? ma[c] : sv18(a_in);
  endfunction

  function automatic longint eff_b(int c);
    return ((c / 2) % 2 != 0) ? mb[c] : sv18(b_in);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int c = 0; c < NCFG; c++) begin
      if (!rst_n) begin
        ma[c] = 0; mb[c] = 0; mp[c] = 0;
      end else begin
        longint prod;
        prod = eff_a(c) * eff_b(c);
        if (p_srst)    mp[c] = 0;
        else if (p_ce) mp[c] = prod;
        if (a_srst)    ma[c] = 0;
        else if (a_ce) ma[c] = sv18(a_in);
        if (b_srst)    mb[c] = 0;
        else if (b_ce) mb[c] = sv18(b_in);
      end
    end
  end

  task automatic check(bit ok, string t, int c, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cfg=%0d act=%0d exp=%0d", t, c, act, exp);
    end
  endtask

  // comparison against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NCFG; c++) begin
        longint exp, act;
        exp = ((c / 4) % 2 != 0) ? mp[c] : eff_a(c) * eff_b(c);
        act = longint'($signed(pv[c]));
        check(act == exp, tag, c, act, exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl(bit ace, bit bce, bit pce, bit ars, bit brs, bit prs);
    a_ce = ace; b_ce = bce; p_ce = pce;
    a_srst = ars; b_srst = brs; p_srst = prs;
  endtask

  task automatic rnd_ops();
    a_in = 18'($urandom);
    b_in = 18'($urandom);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [17:0] ca [7];
    logic [17:0] cb [7];
    logic [16:0] wa [4];
    logic [16:0] wb [4];

    ca[0] = 18'h20000; cb[0] = 18'h20000;   // -131072 * -131072
    ca[1] = 18'h20000; cb[1] = 18'h1FFFF;   // -131072 * 131071
    ca[2] = 18'h1FFFF; cb[2] = 18'h1FFFF;   // 131071 * 131071
    ca[3] = 18'h3FFFF; cb[3] = 18'h3FFFF;   // -1 * -1
    ca[4] = 18'h3FFFF; cb[4] = 18'h1FFFF;   // -1 * 131071
    ca[5] = 18'h00000; cb[5] = 18'h20000;   // 0 * -131072
    ca[6] = 18'd12345; cb[6] = 18'h3FD4A;   // 12345 * -694

    rst_n = 1'b0;
    a_in = 18'd5; b_in = 18'd7;
    ctl(1, 1, 1, 0, 0, 0);
    w_ce = 1'b1; w_srst = 1'b0; ua = '0; ub = '0;
    running = 1'b1;

    // R7: reset state, registered paths read zero
    tag = "R7";
    repeat (3) step();
    rst_n = 1'b1;

    // R1: corner operands, one new pair per cycle
    tag = "R1";
    for (int i = 0; i < 7; i++) begin
      a_in = ca[i]; b_in = cb[i];
      step();
    end
    repeat (3) step();

    // R2: a fresh random pair every cycle exposes each delay
    tag = "R2";
    for (int i = 0; i < 24; i++) begin rnd_ops(); step(); end

    // R3: enables toggling, loads only on enabled edges
    tag = "R3";
    for (int i = 0; i < 16; i++) begin
      ctl(i % 2 == 0, i % 3 == 0, i % 2 == 1, 0, 0, 0);
      rnd_ops(); step();
    end

    // R9: only the A enable low, B and product keep moving
    tag = "R9";
    ctl(0, 1, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin rnd_ops(); step(); end
    ctl(1, 0, 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin rnd_ops(); step(); end

    // R4: every enable low, operands keep changing
    tag = "R4";
    ctl(1, 1, 1, 0, 0, 0);
    a_in = 18'h20000; b_in = 18'h20000; step(); step();
    ctl(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin rnd_ops(); step(); end

    // R5: clear with enables low, then with enables high
    tag = "R5";
    ctl(0, 0, 0, 1, 1, 1);
    for (int i = 0; i < 2; i++) begin rnd_ops(); step(); end
    ctl(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin rnd_ops(); step(); end
    ctl(1, 1, 1, 1, 1, 1);
    for (int i = 0; i < 2; i++) begin rnd_ops(); step(); end

    // R6: enables low and clears high: left-out stages still follow
    tag = "R6";
    ctl(0, 0, 0, 1, 1, 1);
    for (int i = 0; i < 4; i++) begin rnd_ops(); step(); end
    ctl(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin rnd_ops(); step(); end

    // R7: asynchronous reset asserted between edges mid-run
    tag = "R7";
    rst_n = 1'b0;
    for (int i = 0; i < 2; i++) begin rnd_ops(); step(); end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin rnd_ops(); step(); end

    // R8: unsigned front end, product valid two edges after the operands
    wa[0] = 17'h1FFFF; wb[0] = 17'h1FFFF;
    wa[1] = 17'd0;     wb[1] = 17'd5;
    wa[2] = 17'd1;     wb[2] = 17'h1FFFF;
    wa[3] = 17'd1234;  wb[3] = 17'd5678;
    for (int i = 0; i < 4; i++) begin
      longint wexp;
      ua = wa[i]; ub = wb[i];
      step(); step();
      @(negedge clk);
      wexp = longint'(wa[i]) * longint'(wb[i]);
      check(longint'(up) == wexp, "R8", 99, longint'(up), wexp);
      step();
    end

    running = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule